// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block sits between a 12-bit converter core and the parallel output pins. On each sample clock it takes an offset-binary code and an over-range flag from the core. It registers one output word, one over-range bit and a data-ready clock. The word is coded in either straight offset binary or two's complement, and the choice is made at run time.

A two-bit pattern field can replace the sample with fixed patterns or with an alternating pattern, which helps when checking the board-level capture path. An output enable and a power-down control turn off the pad drive, and reset clears the registered word. The data-ready clock can be inverted so that the data is valid on either its rising or its falling edge.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst` is high, every rising `clk` edge clears `dout` to all zeros and `ovr` to 0.
- R2: With `pat_sel` = 0 (pass) and `fmt_twos` = 0, `dout` after a rising edge equals the `core_code` sampled at that edge (straight offset binary).
- R3: With `pat_sel` = 0 and `fmt_twos` = 1, `dout` equals the sampled `core_code` with bit DATA_W-1 (the MSB) inverted. This is two's complement, so mid-scale 0x800 becomes 0x000.
- R4: With `pat_sel` = 0, `ovr` is 1 exactly when the sampled `core_code` is all zeros, all ones, or `core_ovr` was 1. The format selection has no effect on it.
- R5: With `pat_sel` = 1, `dout` is all zeros.
- R6: With `pat_sel` = 2, `dout` is all ones.
- R7: With `pat_sel` = 3, all `dout` bits switch together on every rising edge. The first edge after reset gives all ones, then all zeros, and so on, whatever the values of `core_code` and `fmt_twos`.
- R8: With any `pat_sel` other than 0, `ovr` is 0.
- R9: `pad_en` is 1 only when `oe` is 1 and `pdn` is 0, and it follows these inputs without waiting for a clock edge.
- R10: `dclk` equals the inverse of `clk` when `pol_fall` = 0 (data is valid on the `dclk` rising edge) and equals `clk` when `pol_fall` = 1 (data is valid on the `dclk` falling edge).
- R11: `dout` and `ovr` change only at a rising `clk` edge. A new input shows up after exactly one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| core_code | input | DATA_W | Offset-binary sample from the converter core |
| core_ovr | input | 1 | Over-range flag from the core |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| pat_sel | input | 2 | 0 pass, 1 zeros, 2 ones, 3 alternating |
| oe | input | 1 | Output enable, active high |
| pdn | input | 1 | Power-down, active high |
| pol_fall | input | 1 | Data-ready clock polarity select |
| dout | output | DATA_W | Registered output word, MSB at bit DATA_W-1 |
| ovr | output | 1 | Registered over-range bit |
| dclk | output | 1 | Data-ready clock |
| pad_en | output | 1 | Pad drive enable; 0 means the pins float |

## Verification
The assertions check on every cycle the one-edge mapping from the sampled inputs to `dout` and `ovr` in each pattern mode:
- pass-through in both codings
- the fixed patterns
- the complementing of the word in alternating mode
- the over-range mask in the test modes
- clearing under reset

Some behaviour is left to the bench scenarios:
- the phase of the alternating pattern relative to reset
- that the output holds still between edges
- the combinational pad-enable decode
- the `dclk` levels in each half period under both polarity settings

// File: rtl/adc_out_fmt_pkg.sv
package adc_out_fmt_pkg;
   typedef enum logic [1:0] {
      PAT_PASS   = 2'd0,
      PAT_ZEROS  = 2'd1,
      PAT_ONES   = 2'd2,
      PAT_TOGGLE = 2'd3
   } pat_e;
endpackage

// File: rtl/aof_code.sv
module aof_code #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] raw,
   input  logic              twos,
   input  logic              flag_in,
   output logic [DATA_W-1:0] code,
   output logic              range_hit
);
   localparam int MSB = DATA_W - 1;
   localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

   // flipping the MSB re-centres offset binary onto two's complement
   always_comb begin
      code      = raw;
      code[MSB] = raw[MSB] ^ twos;
   end

   assign range_hit = flag_in | (raw == '0) | (raw == ALL_ONES);
endmodule

// File: rtl/aof_pattern.sv
module aof_pattern
   import adc_out_fmt_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  pat_e              sel,
   input  logic [DATA_W-1:0] code,
   input  logic              range_hit,
   output logic [DATA_W-1:0] nxt_word,
   output logic              nxt_ovr
);
   logic phase_q;

   // alternating phase starts at 1 out of reset and flips every edge
   always_ff @(posedge clk) begin
      if (rst) phase_q <= 1'b1;
      else     phase_q <= ~phase_q;
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_comb begin
         unique case (sel)
            PAT_PASS:   nxt_word[b] = code[b];
            PAT_ZEROS:  nxt_word[b] = 1'b0;
            PAT_ONES:   nxt_word[b] = 1'b1;
            PAT_TOGGLE: nxt_word[b] = phase_q;
            default:    nxt_word[b] = code[b];
         endcase
      end
   end

   assign nxt_ovr = (sel == PAT_PASS) & range_hit;
endmodule

// File: rtl/aof_outclk.sv
module aof_outclk (
   input  logic clk,
   input  logic pol_fall,
   output logic dclk
);
   // data moves on clk rise; an inverted copy rises mid-period
   assign dclk = pol_fall ? clk : ~clk;
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
   import adc_out_fmt_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] core_code,
   input  logic              core_ovr,
   input  logic              fmt_twos,
   input  logic [1:0]        pat_sel,
   input  logic              oe,
   input  logic              pdn,
   input  logic              pol_fall,
   output logic [DATA_W-1:0] dout,
   output logic              ovr,
   output logic              dclk,
   output logic              pad_en
);
   if (DATA_W < 2) begin : g_bad_width
      $error("adc_out_fmt: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] code_w, word_w;
   logic              hit_w, ovr_w;

   aof_code #(.DATA_W(DATA_W)) u_code (
      .raw       (core_code),
      .twos      (fmt_twos),
      .flag_in   (core_ovr),
      .code      (code_w),
      .range_hit (hit_w)
   );

   aof_pattern #(.DATA_W(DATA_W)) u_pat (
      .clk       (clk),
      .rst       (rst),
      .sel       (pat_e'(pat_sel)),
      .code      (code_w),
      .range_hit (hit_w),
      .nxt_word  (word_w),
      .nxt_ovr   (ovr_w)
   );

   aof_outclk u_clk (
      .clk      (clk),
      .pol_fall (pol_fall),
      .dclk     (dclk)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dout <= '0;
         ovr  <= 1'b0;
      end else begin
         dout <= word_w;
         ovr  <= ovr_w;
      end
   end

   assign pad_en = oe & ~pdn;
endmodule

// File: rtl/aof_chk.sv
module aof_chk #(
   parameter int DATA_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic [DATA_W-1:0] core_code,
   input logic              core_ovr,
   input logic              fmt_twos,
   input logic [1:0]        pat_sel,
   input logic [DATA_W-1:0] dout,
   input logic              ovr
);
   localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (dout == '0 && !ovr));

   // R2
   pass_bin_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd0 && !fmt_twos) |=> dout == $past(core_code));

   // R3
   pass_twos_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd0 && fmt_twos) |=> dout == ($past(core_code) ^ TOP_BIT));

   // R4
   range_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd0 && core_ovr) |=> ovr);

   // R5
   zeros_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd1) |=> dout == '0);

   // R6
   ones_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd2) |=> dout == '1);

   // R7
   toggle_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel == 2'd3 && $past(pat_sel) == 2'd3) |=> dout == ~$past(dout));

   // R8
   ovr_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (pat_sel != 2'd0) |=> !ovr);
endmodule

bind adc_out_fmt aof_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .core_code (core_code),
   .core_ovr  (core_ovr),
   .fmt_twos  (fmt_twos),
   .pat_sel   (pat_sel),
   .dout      (dout),
   .ovr       (ovr)
);

// File: tb/adc_out_fmt_tb.sv
module adc_out_fmt_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 12;
   localparam int NVEC = 12;

   // {pat, fmt, core_ovr, code, expected word, expected ovr}
   localparam logic [28:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 1'b0, 12'h123, 12'h123, 1'b0},
      {2'd0, 1'b0, 1'b0, 12'h800, 12'h800, 1'b0},
      {2'd0, 1'b1, 1'b0, 12'h800, 12'h000, 1'b0},
      {2'd0, 1'b1, 1'b0, 12'h7FF, 12'hFFF, 1'b0},
      {2'd0, 1'b0, 1'b0, 12'hFFF, 12'hFFF, 1'b1},
      {2'd0, 1'b1, 1'b0, 12'h000, 12'h800, 1'b1},
      {2'd0, 1'b0, 1'b1, 12'h555, 12'h555, 1'b1},
      {2'd0, 1'b1, 1'b0, 12'hA5A, 12'h25A, 1'b0},
      {2'd1, 1'b0, 1'b1, 12'hFFF, 12'h000, 1'b0},
      {2'd1, 1'b1, 1'b0, 12'h3C3, 12'h000, 1'b0},
      {2'd2, 1'b0, 1'b1, 12'h000, 12'hFFF, 1'b0},
      {2'd2, 1'b1, 1'b0, 12'h123, 12'hFFF, 1'b0}
   };

   logic clk = 1'b0;
   logic rst, core_ovr, fmt_twos, oe, pdn, pol_fall;
   logic [DATA_W-1:0] core_code;
   logic [1:0] pat_sel;
   logic [DATA_W-1:0] dout;
   logic ovr, dclk, pad_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_out_fmt #(.DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst(rst), .core_code(core_code), .core_ovr(core_ovr),
      .fmt_twos(fmt_twos), .pat_sel(pat_sel), .oe(oe), .pdn(pdn),
      .pol_fall(pol_fall), .dout(dout), .ovr(ovr), .dclk(dclk), .pad_en(pad_en)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1; oe = 1; pdn = 0; pol_fall = 0;
      pat_sel = 0; fmt_twos = 0; core_code = 12'hABC; core_ovr = 1;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 dout in reset", dout, 0);
      chk("R1 ovr in reset", ovr, 0);
      @(negedge clk) rst = 0;

      // table walk: R2..R6, R8
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         pat_sel   = VEC[i][28:27];
         fmt_twos  = VEC[i][26];
         core_ovr  = VEC[i][25];
         core_code = VEC[i][24:13];
         @(posedge clk);
         #2;
         if (VEC[i][28:27] == 2'd1)      chk("R5 zeros word", dout, VEC[i][12:1]);
         else if (VEC[i][28:27] == 2'd2) chk("R6 ones word", dout, VEC[i][12:1]);
         else if (VEC[i][26])            chk("R3 twos word", dout, VEC[i][12:1]);
         else                            chk("R2 binary word", dout, VEC[i][12:1]);
         if (VEC[i][28:27] == 2'd0) chk("R4 range flag", ovr, VEC[i][0]);
         else                       chk("R8 ovr masked", ovr, VEC[i][0]);
      end

      // R11: output holds until the edge
      @(negedge clk);
      pat_sel = 0; fmt_twos = 0; core_ovr = 0; core_code = 12'h3AB;
      #1;
      chk("R11 hold before edge", dout, 12'hFFF);
      @(posedge clk);
      #2;
      chk("R11 update after edge", dout, 12'h3AB);

      // R10: clk is high here
      chk("R10 dclk pol0 clk high", dclk, 0);
      pol_fall = 1; #1;
      chk("R10 dclk pol1 clk high", dclk, 1);
      @(negedge clk); #2;
      chk("R10 dclk pol1 clk low", dclk, 0);
      pol_fall = 0; #1;
      chk("R10 dclk pol0 clk low", dclk, 1);

      // R9: pad enable decode
      for (int k = 0; k < 4; k++) begin
         oe = k[0]; pdn = k[1]; #1;
         chk("R9 pad enable", pad_en, (k == 1) ? 1 : 0);
      end
      oe = 1; pdn = 0;

      // R7: alternating pattern phase from reset, inputs ignored
      @(negedge clk);
      rst = 1; pat_sel = 3; fmt_twos = 1; core_code = 12'h000; core_ovr = 1;
      @(posedge clk);
      @(negedge clk) rst = 0;
      for (int j = 0; j < 6; j++) begin
         @(posedge clk);
         #2;
         chk("R7 alternating word", dout, (j % 2 == 0) ? 12'hFFF : 12'h000);
         chk("R8 ovr masked toggle", ovr, 0);
      end

      // R1 again with live data
      @(negedge clk);
      pat_sel = 0; fmt_twos = 0; core_code = 12'h777; rst = 1;
      @(posedge clk);
      #2;
      chk("R1 reset clears word", dout, 0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule